// File: doc/BRIEF.md
# Camera Pixel Word Packer

This block sits behind a camera pixel port and turns a stream of narrow pixel samples into 32-bit words for a data register. On each clock edge it takes at most one sample, marked by a valid strobe, and only while capture is enabled. A 2-bit width select picks how the samples are laid out. In byte mode four samples fill one word. In the 10-bit and 12-bit modes two samples fill one word, one in each half-word, and the unused upper bits are zero.

When a word is complete it appears on the word output together with a one-cycle valid pulse. The word output then holds that value until the next word completes. Dropping the capture enable, or raising the frame-restart input, throws away any partly filled word, so the next word always starts at the lowest slot. Sync decoding, blanking handling, clock-domain crossing and the bus side are handled elsewhere.

Top module: `pixpack_top`

## Requirements
- R1: With width select 0, four accepted samples form one word. Bits 7:0 of the first sample go to word bits 7:0, the second to 15:8, the third to 23:16 and the fourth to 31:24. Sample bits above 7 are dropped.
- R2: With width select 1, two accepted samples form one word. The first sample's bits 9:0 go to word bits 9:0, the second sample's bits 9:0 go to word bits 25:16, and all other word bits are zero.
- R3: With width select 2, two accepted samples form one word. The first sample's bits 11:0 go to word bits 11:0, the second sample's bits 11:0 go to word bits 27:16, and all other word bits are zero.
- R4: Width select 3 packs exactly as width select 0.
- R5: `word_valid` is high for exactly one cycle: the cycle after the edge that accepts the last sample of a word. `word_data` changes only together with that pulse and holds its value otherwise.
- R6: A sample is ignored while `cap_en` is low. Any cycle with `cap_en` low discards the partial word, and the next accepted sample becomes the first sample of a new word.
- R7: `frame_start` high (with `cap_en` high) discards the partial word. A sample presented in that same cycle is accepted as the first sample of the new word.
- R8: Cycles with `smp_valid` low neither advance nor disturb the fill, so gaps between samples do not change the packed result.
- R9: After reset `word_valid` is 0 and `word_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_en | input | 1 | Capture enable; low discards the partial word |
| frame_start | input | 1 | Frame restart; discards the partial word |
| mode | input | 2 | Width select: 0 byte, 1 ten-bit, 2 twelve-bit, 3 as byte |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | PIX_W (12) | Pixel sample |
| word_valid | output | 1 | One-cycle completed-word pulse |
| word_data | output | WORD_W (32) | Last completed word |

## Verification
Two functions can fall in the same cycle. The first is a frame restart arriving together with a sample strobe, which must both discard the old fill and accept the new sample into the lowest slot. The second is a restart landing exactly where the last sample of a word would have gone. The bench provokes both cases by raising `frame_start` with `smp_valid` after three byte samples. A reference model clears its own fill and then takes the sample. The scoreboard then requires that no word appears for the discarded fill and that the next word carries the restart sample in bits 7:0.

// File: rtl/pixpack_pkg.sv
package pixpack_pkg;
   typedef enum logic [1:0] {
      PM_BYTE   = 2'd0,
      PM_TEN    = 2'd1,
      PM_TWELVE = 2'd2,
      PM_SPARE  = 2'd3
   } pix_mode_e;

   function automatic logic is_wide(input logic [1:0] m);
      return (m == PM_TEN) || (m == PM_TWELVE);
   endfunction
endpackage

// File: rtl/pixpack_slot_ctl.sv
module pixpack_slot_ctl #(
   parameter int LANES = 4,
   parameter int CNT_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             restart,
   input  logic             accept,
   input  logic             wide,
   output logic [CNT_W-1:0] slot,
   output logic             last
);
   localparam int HALVES = LANES / 2;

   logic [CNT_W-1:0] cnt_q;

   // a restart presents slot zero so a same-cycle sample opens the new word
   assign slot = restart ? '0 : cnt_q;
   assign last = wide ? (slot == CNT_W'(HALVES - 1)) : (slot == CNT_W'(LANES - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cnt_q <= '0;
      else if (!en)      cnt_q <= '0;
      else if (accept)   cnt_q <= last ? '0 : slot + CNT_W'(1);
      else if (restart)  cnt_q <= '0;
   end
endmodule

// File: rtl/pixpack_merge.sv
module pixpack_merge #(
   parameter int PIX_W  = 12,
   parameter int WORD_W = 32,
   parameter int CNT_W  = 2
) (
   input  logic [WORD_W-1:0] base,
   input  logic [PIX_W-1:0]  sample,
   input  logic [1:0]        mode,
   input  logic [CNT_W-1:0]  slot,
   output logic [WORD_W-1:0] merged
);
   import pixpack_pkg::*;

   localparam int LANES = WORD_W / 8;

   logic        wide;
   logic [15:0] half_val;

   assign wide = is_wide(mode);

   always_comb begin
      half_val = '0;
      if (mode == PM_TWELVE) half_val[11:0] = sample[11:0];
      else                   half_val[9:0]  = sample[9:0];
   end

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      localparam int HALF = i / 2;
      localparam int SUB  = i % 2;
      logic hit_b;
      logic hit_h;
      assign hit_b = !wide && (slot == CNT_W'(i));
      assign hit_h = wide && (slot == CNT_W'(HALF));
      assign merged[8*i +: 8] = hit_b ? sample[7:0] :
                                hit_h ? half_val[8*SUB +: 8] :
                                        base[8*i +: 8];
   end
endmodule

// File: rtl/pixpack_top.sv
module pixpack_top #(
   parameter int PIX_W  = 12,
   parameter int WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap_en,
   input  logic              frame_start,
   input  logic [1:0]        mode,
   input  logic              smp_valid,
   input  logic [PIX_W-1:0]  smp_data,
   output logic              word_valid,
   output logic [WORD_W-1:0] word_data
);
   import pixpack_pkg::*;

   localparam int LANES = WORD_W / 8;
   localparam int CNT_W = (LANES > 1) ? $clog2(LANES) : 1;

   if (PIX_W < 12) begin : g_bad_pix
      $error("pixpack_top: PIX_W must be at least 12");
   end
   if ((WORD_W % 16) != 0 || LANES < 2 || (LANES & (LANES - 1)) != 0) begin : g_bad_word
      $error("pixpack_top: WORD_W must be 16 times a power of two");
   end

   logic              accept;
   logic              restart;
   logic [CNT_W-1:0]  slot;
   logic              last;
   logic [WORD_W-1:0] acc_q;
   logic [WORD_W-1:0] base;
   logic [WORD_W-1:0] merged;

   assign accept  = cap_en && smp_valid;
   assign restart = cap_en && frame_start;
   assign base    = (slot == '0) ? '0 : acc_q;

   pixpack_slot_ctl #(.LANES(LANES), .CNT_W(CNT_W)) u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (cap_en),
      .restart (restart),
      .accept  (accept),
      .wide    (is_wide(mode)),
      .slot    (slot),
      .last    (last)
   );

   pixpack_merge #(.PIX_W(PIX_W), .WORD_W(WORD_W), .CNT_W(CNT_W)) u_merge (
      .base   (base),
      .sample (smp_data),
      .mode   (mode),
      .slot   (slot),
      .merged (merged)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q      <= '0;
         word_valid <= 1'b0;
         word_data  <= '0;
      end else begin
         word_valid <= accept && last;
         if (accept) begin
            if (last) begin
               word_data <= merged;
               acc_q     <= '0;
            end else begin
               acc_q <= merged;
            end
         end
      end
   end
endmodule

// File: rtl/pixpack_chk.sv
module pixpack_chk #(
   parameter int PIX_W  = 12,
   parameter int WORD_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cap_en,
   input logic              frame_start,
   input logic [1:0]        mode,
   input logic              smp_valid,
   input logic [PIX_W-1:0]  smp_data,
   input logic              word_valid,
   input logic [WORD_W-1:0] word_data
);
   AST_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      word_valid |=> !word_valid); // R5
   AST_AFTER_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
      word_valid |-> $past(cap_en && smp_valid)); // R5
   AST_HOLD_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      !word_valid |-> $stable(word_data)); // R5
   AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!cap_en) |-> !word_valid); // R6
   AST_TEN_PAD: assert property (@(posedge clk) disable iff (!rst_n)
      (word_valid && $past(mode) == 2'd1) |-> ((word_data[31:0] & 32'hFC00_FC00) == 32'h0)); // R2
   AST_TWELVE_PAD: assert property (@(posedge clk) disable iff (!rst_n)
      (word_valid && $past(mode) == 2'd2) |-> ((word_data[31:0] & 32'hF000_F000) == 32'h0)); // R3
   AST_BYTE_TOP: assert property (@(posedge clk) disable iff (!rst_n)
      (word_valid && ($past(mode) == 2'd0 || $past(mode) == 2'd3))
         |-> (word_data[31:24] == $past(smp_data[7:0]))); // R1
endmodule

bind pixpack_top pixpack_chk #(.PIX_W(PIX_W), .WORD_W(WORD_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cap_en      (cap_en),
   .frame_start (frame_start),
   .mode        (mode),
   .smp_valid   (smp_valid),
   .smp_data    (smp_data),
   .word_valid  (word_valid),
   .word_data   (word_data)
);

// File: tb/sim_pixpack_top.sv
`timescale 1ns/1ps
module sim_pixpack_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cap_en = 1'b0;
   logic        frame_start = 1'b0;
   logic [1:0]  mode = 2'd0;
   logic        smp_valid = 1'b0;
   logic [11:0] smp_data = '0;
   logic        word_valid;
   logic [31:0] word_data;

   int n_cmp = 0;
   int n_bad = 0;
   int ref_cnt = 0;
   logic [31:0] ref_acc = '0;
   logic [31:0] exp_q[$];
   string       tag_q[$];

   always #2 clk = ~clk;

   pixpack_top u0 (
      .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .frame_start(frame_start),
      .mode(mode), .smp_valid(smp_valid), .smp_data(smp_data),
      .word_valid(word_valid), .word_data(word_data)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   // reference packing written from the requirements
   task automatic model_take(input logic [11:0] d, input string tag);
      int lanes;
      logic wide;
      wide  = (mode == 2'd1) || (mode == 2'd2);
      lanes = wide ? 2 : 4;
      if (ref_cnt == 0) ref_acc = '0;
      if (mode == 2'd1)      ref_acc[16*ref_cnt +: 16] = {6'b0, d[9:0]};
      else if (mode == 2'd2) ref_acc[16*ref_cnt +: 16] = {4'b0, d[11:0]};
      else                   ref_acc[8*ref_cnt +: 8]   = d[7:0];
      ref_cnt++;
      if (ref_cnt == lanes) begin
         exp_q.push_back(ref_acc);
         tag_q.push_back(tag);
         ref_cnt = 0;
      end
   endtask

   task automatic send(input logic [11:0] d, input string tag);
      @(negedge clk);
      cap_en = 1'b1; frame_start = 1'b0; smp_valid = 1'b1; smp_data = d;
      model_take(d, tag);
   endtask

   task automatic gap(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         frame_start = 1'b0; smp_valid = 1'b0; smp_data = 12'hABC;
      end
   endtask

   task automatic off_cycle(input logic [11:0] d);
      @(negedge clk);
      cap_en = 1'b0; frame_start = 1'b0; smp_valid = 1'b1; smp_data = d;
      ref_cnt = 0;
   endtask

   task automatic restart_with(input logic [11:0] d, input logic take, input string tag);
      @(negedge clk);
      cap_en = 1'b1; frame_start = 1'b1; smp_valid = take; smp_data = d;
      ref_cnt = 0;
      if (take) model_take(d, tag);
   endtask

   task automatic set_mode(input logic [1:0] m);
      @(negedge clk);
      frame_start = 1'b0; smp_valid = 1'b0; mode = m;
   endtask

   // scoreboard monitor
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && word_valid) begin
            if (exp_q.size() == 0) begin
               chk("R6/R7 unexpected word", word_data, 32'hxxxx_xxxx);
            end else begin
               chk(tag_q.pop_front(), word_data, exp_q.pop_front());
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R9 valid at reset", {31'b0, word_valid}, 32'h0);
      chk("R9 data at reset", word_data, 32'h0);
      rst_n = 1'b1;
      gap(2);

      // R1 byte packing, upper sample bits ignored
      set_mode(2'd0);
      send(12'hF01, "R1"); send(12'hE23, "R1"); send(12'hD45, "R1"); send(12'hC67, "R1");
      send(12'h089, "R1"); send(12'h1AB, "R1"); send(12'h2CD, "R1"); send(12'h3EF, "R1");
      // R8 gaps between samples
      send(12'h011, "R8"); gap(3); send(12'h022, "R8"); gap(1);
      send(12'h033, "R8"); gap(5); send(12'h044, "R8");
      gap(2);

      // R5 pulse timing and hold
      send(12'h0A1, "R5"); send(12'h0B2, "R5"); send(12'h0C3, "R5"); send(12'h0D4, "R5");
      @(negedge clk); smp_valid = 1'b0;
      chk("R5 pulse cycle", {31'b0, word_valid}, 32'h1);
      @(negedge clk);
      chk("R5 pulse ends", {31'b0, word_valid}, 32'h0);
      chk("R5 data held", word_data, 32'hD4C3B2A1);
      gap(2);

      // R2 ten-bit with padding
      set_mode(2'd1);
      send(12'hFFF, "R2"); send(12'h155, "R2");
      send(12'hC00, "R2"); send(12'h3FF, "R2");
      send(12'h2AA, "R2"); gap(2); send(12'hFFF, "R2");
      gap(2);

      // R3 twelve-bit with padding
      set_mode(2'd2);
      send(12'hFFF, "R3"); send(12'hFFF, "R3");
      send(12'h123, "R3"); send(12'hABC, "R3");
      gap(2);

      // R4 spare mode acts as byte
      set_mode(2'd3);
      send(12'h178, "R4"); send(12'h256, "R4"); send(12'h334, "R4"); send(12'h412, "R4");
      gap(2);

      // R6 disable discards partial word, ignores samples
      set_mode(2'd0);
      send(12'h0EE, "R6"); send(12'h0DD, "R6");
      off_cycle(12'h099); off_cycle(12'h088);
      send(12'h001, "R6"); send(12'h002, "R6"); send(12'h003, "R6"); send(12'h004, "R6");
      gap(2);
      off_cycle(12'h0F0); off_cycle(12'h0F1); off_cycle(12'h0F2); off_cycle(12'h0F3);
      gap(2);
      chk("R6 no word while off", {31'b0, word_valid}, 32'h0);

      // R7 restart with same-cycle sample at the last-slot position
      send(12'h0AA, "R7"); send(12'h0BB, "R7"); send(12'h0CC, "R7");
      restart_with(12'h05A, 1'b1, "R7");
      send(12'h06B, "R7"); send(12'h07C, "R7"); send(12'h08D, "R7");
      gap(1);
      // R7 restart without a sample, in ten-bit mode
      set_mode(2'd1);
      send(12'h111, "R7");
      restart_with(12'h3FF, 1'b0, "R7");
      send(12'h222, "R7"); send(12'h333, "R7");
      gap(4);

      chk("R5 all words seen", exp_q.size(), 32'h0);
      finish_run();
   end
endmodule